// File: doc/BRIEF.md
# Memory CRC Checker with Test-Port Loadable Reference

The block holds a small word-wide configuration memory and guards it with a 32-bit CRC. During a configuration phase a host writes the memory once, in address order. While the words arrive, the block folds them into a running CRC. A done pulse then freezes that value as the reference and moves the block into user mode. In user mode a sequencer reads the whole memory again and again. It recomputes the CRC on each pass and compares it with the reference. The first mismatch raises a sticky, active-high error flag. The same flag is also brought out as a low-active pull-down enable, which suits an open-drain pin.

A small JTAG-style test access port sits beside the checker, clocked from the system clock through a TCK-event strobe. One 10-bit instruction selects the 32-bit reference register as the scan path between TDI and TDO. A test host can read the reference back through that path. It can also overwrite the reference while the checker runs, which forces a controlled mismatch and proves the error path without touching the memory. Such overwrites take effect only in user mode.

Top module: `cfg_crc_monitor`

## Requirements
- R1: After reset the block is in the configuration phase. In that state user_mode_o and crc_err_o are low, crc_err_pd_n_o is high, and the test port is in Test-Logic-Reset with the bypass instruction (all ones) loaded.
- R2: In the configuration phase, cfg_we_i writes cfg_wdata_i to cfg_addr_i and folds the word into the configuration CRC. cfg_done_i latches the finished CRC as the reference and sets user_mode_o on the next edge. A cfg_we_i pulse in user mode changes neither the memory nor the running CRC.
- R3: The CRC is the reflected form of polynomial 0x04C11DB7 (right shift, constant 0xEDB88320). It starts at 0xFFFFFFFF, is XORed with 0xFFFFFFFF at the end, and consumes each 32-bit word bit 0 first, with address 0 first.
- R4: In user mode a pass lasts DEPTH+1 cycles: addresses 0 to DEPTH-1, one per cycle, then one compare cycle, and then the next pass begins at once. After a mismatching reference is committed, crc_err_o rises within DEPTH+2 cycles.
- R5: When a compare finds that the recomputed CRC differs from the reference, crc_err_o goes high and crc_err_pd_n_o goes low. While the two agree, both keep their idle levels.
- R6: Once set, the error flag stays set, even after later passes that match. Only rst_n or cfg_start_i clears it.
- R7: The instruction register is 10 bits wide. Capture-IR loads 0b0000000001, shifted out bit 0 first. Code 0x015 selects the 32-bit reference path. Every other code selects a 1-bit bypass cell that captures 0.
- R8: With the reference path selected, Capture-DR loads the current reference. Shift-DR moves bits in at TDI and out at TDO, bit 0 first. Update-DR writes the shifted value into the reference when the block is in user mode.
- R9: An Update-DR that happens during the configuration phase leaves the reference unchanged.
- R10: cfg_start_i returns the block to the configuration phase, clears the error flag and restarts the configuration CRC at its initial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_i | input | 1 | Pulse: begin a new configuration phase |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_done_i | input | 1 | Pulse: configuration complete, latch reference |
| tap_tck_en_i | input | 1 | One-cycle strobe marking a TCK rising edge |
| tap_tms_i | input | 1 | Test mode select |
| tap_tdi_i | input | 1 | Test data in |
| tap_tdo_o | output | 1 | Test data out |
| user_mode_o | output | 1 | High in user mode |
| crc_err_o | output | 1 | Sticky CRC mismatch flag, active high |
| crc_err_pd_n_o | output | 1 | Low-active pull-down enable for the error pin |

## Verification
Assertions check five things on every cycle:
- the error flag rises only in the cycle after a compare;
- the flag stays set unless a configuration phase starts;
- the reference is frozen during the configuration phase except at the done pulse;
- the scan counter stays in range, and compares never fall in back-to-back cycles;
- a done pulse always leads into user mode.

Some properties need whole multi-step sequences, so only the bench's scenarios can show them:
- the CRC value itself and the TAP capture patterns;
- the LSB-first order of the scan path and the one-cycle delay of the bypass cell;
- the rule that an Update-DR issued in the configuration phase, or a memory write issued in user mode, leaves no trace.

// File: rtl/crcmon_pkg.sv
package crcmon_pkg;

  localparam int          CRC_W       = 32;
  localparam logic [31:0] CRC_POLY_RV = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_XOROUT  = 32'hFFFF_FFFF;

  localparam int          IR_W        = 10;
  localparam logic [9:0]  IR_REFPATH  = 10'h015;
  localparam logic [9:0]  IR_BYPASS   = 10'h3FF;
  localparam logic [9:0]  IR_CAPTURE  = 10'b00_0000_0001;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  // Fold one 32-bit word into a reflected CRC register, bit 0 first.
  function automatic logic [31:0] crc_fold(input logic [31:0] acc, input logic [31:0] word);
    logic [31:0] c;
    logic        fb;
    c = acc;
    for (int i = 0; i < 32; i++) begin
      fb = c[0] ^ word[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_RV;
    end
    return c;
  endfunction

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    unique case (s)
      TS_RESET:  n = tms ? TS_RESET   : TS_IDLE;
      TS_IDLE:   n = tms ? TS_SEL_DR  : TS_IDLE;
      TS_SEL_DR: n = tms ? TS_SEL_IR  : TS_CAP_DR;
      TS_CAP_DR: n = tms ? TS_EX1_DR  : TS_SH_DR;
      TS_SH_DR:  n = tms ? TS_EX1_DR  : TS_SH_DR;
      TS_EX1_DR: n = tms ? TS_UPD_DR  : TS_PAU_DR;
      TS_PAU_DR: n = tms ? TS_EX2_DR  : TS_PAU_DR;
      TS_EX2_DR: n = tms ? TS_UPD_DR  : TS_SH_DR;
      TS_UPD_DR: n = tms ? TS_SEL_DR  : TS_IDLE;
      TS_SEL_IR: n = tms ? TS_RESET   : TS_CAP_IR;
      TS_CAP_IR: n = tms ? TS_EX1_IR  : TS_SH_IR;
      TS_SH_IR:  n = tms ? TS_EX1_IR  : TS_SH_IR;
      TS_EX1_IR: n = tms ? TS_UPD_IR  : TS_PAU_IR;
      TS_PAU_IR: n = tms ? TS_EX2_IR  : TS_PAU_IR;
      TS_EX2_IR: n = tms ? TS_UPD_IR  : TS_SH_IR;
      TS_UPD_IR: n = tms ? TS_SEL_DR  : TS_IDLE;
      default:   n = TS_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/crcmon_tap.sv
module crcmon_tap
  import crcmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tck_en,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic [CRC_W-1:0]  ref_cur,
  output logic              ref_commit,
  output logic [CRC_W-1:0]  ref_shifted
);

  tap_state_e         st_q;
  logic [IR_W-1:0]    ir_q, ir_sh_q;
  logic [CRC_W-1:0]   dr_sh_q;
  logic               byp_q;
  logic               sel_ref;

  assign sel_ref = (ir_q == IR_REFPATH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TS_RESET;
      ir_q    <= IR_BYPASS;
      ir_sh_q <= '0;
      dr_sh_q <= '0;
      byp_q   <= 1'b0;
    end else if (tck_en) begin
      st_q <= tap_next(st_q, tms);
      unique case (st_q)
        TS_RESET:  ir_q    <= IR_BYPASS;
        TS_CAP_IR: ir_sh_q <= IR_CAPTURE;
        TS_SH_IR:  ir_sh_q <= {tdi, ir_sh_q[IR_W-1:1]};
        TS_UPD_IR: ir_q    <= ir_sh_q;
        TS_CAP_DR: begin
          if (sel_ref) dr_sh_q <= ref_cur;
          else         byp_q   <= 1'b0;
        end
        TS_SH_DR: begin
          if (sel_ref) dr_sh_q <= {tdi, dr_sh_q[CRC_W-1:1]};
          else         byp_q   <= tdi;
        end
        default: ;
      endcase
    end
  end

  // Commit fires on the strobe taken while in Update-DR.
  assign ref_commit  = tck_en && (st_q == TS_UPD_DR) && sel_ref;
  assign ref_shifted = dr_sh_q;

  always_comb begin
    if (st_q == TS_SH_IR)      tdo = ir_sh_q[0];
    else if (st_q == TS_SH_DR) tdo = sel_ref ? dr_sh_q[0] : byp_q;
    else                       tdo = 1'b0;
  end

endmodule

// File: rtl/crcmon_scan.sv
module crcmon_scan
  import crcmon_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CRC_W-1:0]  wr_data,
  output logic              cmp_fire,
  output logic [CRC_W-1:0]  crc_result
);

  logic [CRC_W-1:0]  mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [CRC_W-1:0]  acc_q;
  logic [ADDR_W-1:0] rd_idx;
  logic [CRC_W-1:0]  acc_base;

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) mem_q[wr_addr] <= wr_data;
  end

  assign rd_idx     = cnt_q[ADDR_W-1:0];
  assign acc_base   = (cnt_q == '0) ? CRC_SEED : acc_q;
  assign cmp_fire   = run && (int'(cnt_q) == DEPTH);
  assign crc_result = acc_q ^ CRC_XOROUT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= CRC_SEED;
    end else if (!run) begin
      cnt_q <= '0;
      acc_q <= CRC_SEED;
    end else if (int'(cnt_q) == DEPTH) begin
      cnt_q <= '0;
    end else begin
      acc_q <= crc_fold(acc_base, mem_q[rd_idx]);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  p_cmp_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> !cmp_fire);

endmodule

// File: rtl/cfg_crc_monitor.sv
module cfg_crc_monitor
  import crcmon_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              cfg_done_i,
  input  logic              tap_tck_en_i,
  input  logic              tap_tms_i,
  input  logic              tap_tdi_i,
  output logic              tap_tdo_o,
  output logic              user_mode_o,
  output logic              crc_err_o,
  output logic              crc_err_pd_n_o
);

  logic              user_q;
  logic              err_q;
  logic [CRC_W-1:0]  ref_q;
  logic [CRC_W-1:0]  cfg_acc_q;

  logic              cfg_wr;
  logic              cmp_fire;
  logic [CRC_W-1:0]  crc_result;
  logic              mismatch;
  logic              tap_commit;
  logic [CRC_W-1:0]  tap_value;

  assign cfg_wr   = cfg_we_i && !user_q && !cfg_start_i;
  assign mismatch = cmp_fire && (crc_result != ref_q);

  crcmon_scan #(.DEPTH(DEPTH)) scan_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (user_q),
    .wr_en      (cfg_wr),
    .wr_addr    (cfg_addr_i),
    .wr_data    (cfg_wdata_i),
    .cmp_fire   (cmp_fire),
    .crc_result (crc_result)
  );

  crcmon_tap tap_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tck_en      (tap_tck_en_i),
    .tms         (tap_tms_i),
    .tdi         (tap_tdi_i),
    .tdo         (tap_tdo_o),
    .ref_cur     (ref_q),
    .ref_commit  (tap_commit),
    .ref_shifted (tap_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q    <= 1'b0;
      err_q     <= 1'b0;
      ref_q     <= '0;
      cfg_acc_q <= CRC_SEED;
    end else if (cfg_start_i) begin
      user_q    <= 1'b0;
      err_q     <= 1'b0;
      cfg_acc_q <= CRC_SEED;
    end else if (!user_q) begin
      if (cfg_wr) cfg_acc_q <= crc_fold(cfg_acc_q, cfg_wdata_i);
      if (cfg_done_i) begin
        ref_q  <= cfg_acc_q ^ CRC_XOROUT;
        user_q <= 1'b1;
      end
    end else begin
      if (tap_commit) ref_q <= tap_value;
      if (mismatch)   err_q <= 1'b1;
    end
  end

  assign user_mode_o    = user_q;
  assign crc_err_o      = err_q;
  assign crc_err_pd_n_o = !err_q;

  p_err_after_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(cmp_fire));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !cfg_start_i) |=> err_q);

  p_ref_frozen_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_q && !cfg_done_i) |=> $stable(ref_q));

  p_user_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done_i && !cfg_start_i) |=> user_q);

endmodule

// File: tb/cfg_crc_monitor_tb_top.sv
`timescale 1ns/1ps
module cfg_crc_monitor_tb_top;

  localparam int DEPTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PASS   = DEPTH + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_start = 1'b0;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              cfg_done = 1'b0;
  logic              tck_en = 1'b0;
  logic              tms = 1'b1;
  logic              tdi = 1'b0;
  logic              tdo;
  logic              user_mode;
  logic              crc_err;
  logic              crc_err_pd_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] img [DEPTH];
  logic [31:0] ref_a, ref_b;

  always #10 clk = ~clk;

  cfg_crc_monitor #(.DEPTH(DEPTH)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start_i    (cfg_start),
    .cfg_we_i       (cfg_we),
    .cfg_addr_i     (cfg_addr),
    .cfg_wdata_i    (cfg_wdata),
    .cfg_done_i     (cfg_done),
    .tap_tck_en_i   (tck_en),
    .tap_tms_i      (tms),
    .tap_tdi_i      (tdi),
    .tap_tdo_o      (tdo),
    .user_mode_o    (user_mode),
    .crc_err_o      (crc_err),
    .crc_err_pd_n_o (crc_err_pd_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Non-reflected MSB-first register over bit-0-first data, reversed at the end.
  function automatic logic [31:0] model_crc();
    logic [31:0] c;
    logic        top;
    logic [31:0] r;
    c = 32'hFFFF_FFFF;
    for (int w = 0; w < DEPTH; w++)
      for (int b = 0; b < 32; b++) begin
        top = c[31] ^ img[w][b];
        c   = {c[30:0], 1'b0};
        if (top) c = c ^ 32'h04C1_1DB7;
      end
    c = ~c;
    for (int b = 0; b < 32; b++) r[b] = c[31-b];
    return r;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tck(input logic m, input logic d, output logic so);
    @(negedge clk);
    so = tdo;
    tms = m; tdi = d; tck_en = 1'b1;
    @(negedge clk);
    tck_en = 1'b0;
  endtask

  task automatic tap_idle();
    logic s;
    for (int i = 0; i < 5; i++) tck(1'b1, 1'b0, s);
    tck(1'b0, 1'b0, s);
  endtask

  task automatic tap_ir(input logic [9:0] code, output logic [9:0] cap);
    logic s;
    tck(1'b1, 1'b0, s); tck(1'b1, 1'b0, s); tck(1'b0, 1'b0, s); tck(1'b0, 1'b0, s);
    for (int i = 0; i < 10; i++) begin
      tck(i == 9, code[i], s);
      cap[i] = s;
    end
    tck(1'b1, 1'b0, s); tck(1'b0, 1'b0, s);
  endtask

  task automatic tap_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic s;
    dout = '0;
    tck(1'b1, 1'b0, s); tck(1'b0, 1'b0, s); tck(1'b0, 1'b0, s);
    for (int i = 0; i < n; i++) begin
      tck(i == n - 1, din[i], s);
      dout[i] = s;
    end
    tck(1'b1, 1'b0, s); tck(1'b0, 1'b0, s);
  endtask

  task automatic load_image(input logic [31:0] seed);
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      img[i] = (seed * 32'h9E37_79B9) ^ (i * 32'h0101_0101) ^ {i[7:0], 24'h5A_C3_0F};
      cfg_we = 1'b1; cfg_addr = i[ADDR_W-1:0]; cfg_wdata = img[i];
      @(negedge clk);
    end
    cfg_we = 1'b0;
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 user_mode after reset", user_mode, 0);
    check("R1 crc_err after reset", crc_err, 0);
    check("R1 pd_n after reset", crc_err_pd_n, 1);
  endtask

  task automatic t_bypass_default();
    logic [31:0] o;
    // Reset leaves bypass selected: captured 0, then TDI delayed by one.
    tap_idle();
    tap_dr(8, 32'h0000_00B5, o);
    check("R1 bypass after reset", o[7:0], {8'h6A});
  endtask

  task automatic t_config_and_match();
    logic [9:0] cap;
    logic [31:0] o;
    load_image(32'd3);
    ref_a = model_crc();
    check("R2 user_mode after done", user_mode, 1);
    wait_cyc(3 * PASS);
    check("R5 no error on match", crc_err, 0);
    check("R5 pd_n idle on match", crc_err_pd_n, 1);
    tap_ir(10'h015, cap);
    check("R7 IR capture pattern", cap, 10'b00_0000_0001);
    tap_dr(32, ref_a, o);
    check("R3 R8 reference readback", o, ref_a);
    wait_cyc(3 * PASS);
    check("R8 rewrite same ref keeps clean", crc_err, 0);
  endtask

  task automatic t_user_write_ignored();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3; cfg_wdata = ~img[3];
    @(negedge clk);
    cfg_we = 1'b0;
    wait_cyc(3 * PASS);
    check("R2 user-mode write ignored", crc_err, 0);
  endtask

  task automatic t_force_mismatch();
    logic [31:0] o;
    int lat;
    tap_dr(32, ref_a ^ 32'h0000_0100, o);
    lat = 0;
    while (!crc_err && lat < 4 * PASS) begin
      @(negedge clk); lat++;
    end
    check("R5 error raised", crc_err, 1);
    check("R5 pd_n driven low", crc_err_pd_n, 0);
    check("R4 error latency bound", (lat <= PASS + 1), 1);
    tap_dr(32, ref_a, o);
    check("R8 shifted-out value", o, ref_a ^ 32'h0000_0100);
    wait_cyc(3 * PASS);
    check("R6 error sticky after match", crc_err, 1);
  endtask

  task automatic t_config_update_ignored();
    logic [31:0] o;
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    check("R10 error cleared by start", crc_err, 0);
    check("R10 back in config", user_mode, 0);
    tap_dr(32, 32'hDEAD_BEEF, o);
    tap_dr(32, 32'h1234_5678, o);
    check("R9 update ignored in config", o, ref_a);
  endtask

  task automatic t_second_image();
    logic [31:0] o;
    logic [9:0]  cap;
    load_image(32'd77);
    ref_b = model_crc();
    wait_cyc(3 * PASS);
    check("R10 R5 new image clean", crc_err, 0);
    tap_dr(32, ref_b, o);
    check("R3 second reference", o, ref_b);
    tap_ir(10'h2A0, cap);
    tap_dr(32, 32'h0BAD_F00D, o);
    wait_cyc(3 * PASS);
    check("R7 other code leaves ref", crc_err, 0);
    tap_ir(10'h015, cap);
    tap_dr(32, ref_b, o);
    check("R7 ref intact after bypass", o, ref_b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_bypass_default();
    t_config_and_match();
    t_user_write_ignored();
    t_force_mismatch();
    t_config_update_ignored();
    t_second_image();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule